// File: doc/BRIEF.md
# Serial Autobuffering Transfer Unit

This block sits between a serial shifter and on-chip memory and moves words in both directions without processor help. A received word from the shifter is written straight into a circular buffer. A transmit word request from the shifter is answered by reading the next word of a second circular buffer. Each direction has its own base address and length inside an 11-bit (2K-word) address window. Each direction is armed with a start pulse and disarmed with a stop pulse. While a direction is disarmed, its word events are passed on as plain per-word interrupt pulses for software to service.

Words of 8, 10, 12 or 16 bits are carried right-justified. Received words are zero-filled above the selected size, and transmit words are trimmed to that size. Each direction pulses an interrupt when its offset reaches the middle of the buffer and another when it wraps back to the base. An optional auto-stop disarms the direction at the first such boundary.

In continuous framing, a frame sync that arrives while the offset is not at the base reveals lost or extra words, and raises a misalignment pulse. In burst framing, syncs come with every word, so no misalignment pulse is raised. Memory is a plain synchronous RAM, with one write port for receive and one read port for transmit.

Top module: `serial_autobuffer`

## Requirements
- R1: During and after reset both directions are disarmed, and every interrupt, memory strobe and `tx_word_load` is low.
- R2: While receive is armed, each `rx_word_valid` produces one `mem_wr_en` pulse in the next cycle. Its address is (`rx_base` + offset) modulo 2048. The offset starts at 0, rises by one per word and returns to 0 after `rx_len` words.
- R3: `word_size` selects the word width: 0 = 8 bits, 1 = 10 bits, 2 = 12 bits, 3 = 16 bits. Written receive data and `tx_word_data` keep the low bits of that width and carry zeros above it.
- R4: A transfer that brings the offset to floor(len/2) pulses the direction's half interrupt one cycle later. A transfer that completes the buffer pulses its wrap interrupt one cycle later.
- R5: While a direction is disarmed, each of its word events pulses its word interrupt one cycle later and causes no memory access.
- R6: With auto-stop set, the transfer that raises a half or wrap interrupt also disarms the direction. The next word event then passes through as a word interrupt.
- R7: With `frame_cont` = 1 and the direction armed, a frame sync that arrives while the offset is not 0 pulses the misalignment interrupt one cycle later. With `frame_cont` = 0, or with the offset at 0, no misalignment pulse is raised.
- R8: While transmit is armed, `tx_word_req` raises `mem_rd_en` with the circular address in the next cycle. `tx_word_load` is high one cycle after that, with the read word on `tx_word_data`.
- R9: A start pulse arms the direction and sets its offset to 0. A stop pulse disarms it. The two directions are controlled independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_start | input | 1 | Arm receive, offset to 0 |
| rx_stop | input | 1 | Disarm receive |
| rx_base | input | 11 | Receive buffer base address |
| rx_len | input | 12 | Receive buffer length, 1..2048 |
| rx_autodis | input | 1 | Receive auto-stop at half/wrap |
| tx_start | input | 1 | Arm transmit, offset to 0 |
| tx_stop | input | 1 | Disarm transmit |
| tx_base | input | 11 | Transmit buffer base address |
| tx_len | input | 12 | Transmit buffer length, 1..2048 |
| tx_autodis | input | 1 | Transmit auto-stop at half/wrap |
| word_size | input | 2 | Word width select |
| frame_cont | input | 1 | 1 = continuous framing, 0 = burst framing |
| rx_fsync | input | 1 | Receive frame sync pulse |
| rx_word_valid | input | 1 | Received word available |
| rx_word_data | input | 16 | Received word, right-justified |
| tx_fsync | input | 1 | Transmit frame sync pulse |
| tx_word_req | input | 1 | Shifter requests next transmit word |
| tx_word_data | output | 16 | Transmit word, trimmed to size |
| tx_word_load | output | 1 | `tx_word_data` valid |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 11 | Memory write address |
| mem_wr_data | output | 16 | Memory write data |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 11 | Memory read address |
| mem_rd_data | input | 16 | Memory read data, one cycle after `mem_rd_en` |
| rx_active | output | 1 | Receive armed |
| tx_active | output | 1 | Transmit armed |
| rx_word_irq | output | 1 | Receive pass-through word interrupt |
| rx_half_irq | output | 1 | Receive half-buffer interrupt |
| rx_wrap_irq | output | 1 | Receive wrap interrupt |
| rx_misalign_irq | output | 1 | Receive misalignment interrupt |
| tx_word_irq | output | 1 | Transmit pass-through word interrupt |
| tx_half_irq | output | 1 | Transmit half-buffer interrupt |
| tx_wrap_irq | output | 1 | Transmit wrap interrupt |
| tx_misalign_irq | output | 1 | Transmit misalignment interrupt |

## Verification
The bench places the receive buffer across the top of the 2K window, so a design that wraps at 2048 by clamping, or wraps the offset at length minus one, writes to the wrong address. It changes the word size on every vector: a design that leaves stale upper bits, or masks to the wrong width, shows up in the written data. Frame syncs are sent at offset 0 and at a non-zero offset, in both framing modes; a design that flags syncs in burst mode or at the base is caught. Auto-stop is checked by sending one more word after the half boundary, which must pass through rather than be written.

// File: rtl/sab_pkg.sv
`timescale 1ns/1ps
package sab_pkg;
   localparam int unsigned NUM_SIZES = 4;
   typedef logic [1:0] wsel_t;
   typedef enum logic {FRM_BURST = 1'b0, FRM_CONT = 1'b1} frame_mode_e;
endpackage

// File: rtl/sab_wmask.sv
`timescale 1ns/1ps
module sab_wmask
   import sab_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned SZ_W [NUM_SIZES] = '{8, 10, 12, 16}
)(
   input  wsel_t             sel_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] dout_o
);
   logic [DATA_W-1:0] tab [NUM_SIZES];

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_tab
      if (SZ_W[g] == 0 || SZ_W[g] > DATA_W) begin : g_bad
         $error("sab_wmask: size entry out of range");
      end
      assign tab[g] = DATA_W'((33'd1 << SZ_W[g]) - 33'd1);
   end

   assign dout_o = din_i & tab[sel_i];
endmodule

// File: rtl/sab_ring.sv
`timescale 1ns/1ps
module sab_ring
   import sab_pkg::*;
#(
   parameter int unsigned ADDR_W = 11,
   localparam int unsigned LEN_W = ADDR_W + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              step_i,
   input  logic              fsync_i,
   input  logic              cont_i,
   input  logic              autodis_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic              run_o,
   output logic              take_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              half_o,
   output logic              wrap_o,
   output logic              mis_o
);
   logic [ADDR_W-1:0] off_q;
   logic [LEN_W-1:0]  nxt;
   logic              at_half, at_end;

   assign nxt     = {1'b0, off_q} + LEN_W'(1);
   assign at_half = (nxt == (len_i >> 1));
   assign at_end  = (nxt == len_i);
   assign take_o  = step_i & run_o & ~start_i & ~stop_i;
   assign addr_o  = base_i + off_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_o  <= 1'b0;
         off_q  <= '0;
         half_o <= 1'b0;
         wrap_o <= 1'b0;
         mis_o  <= 1'b0;
      end else begin
         half_o <= 1'b0;
         wrap_o <= 1'b0;
         mis_o  <= fsync_i & run_o & (frame_mode_e'(cont_i) == FRM_CONT) & (off_q != '0);
         if (start_i) begin
            run_o <= 1'b1;
            off_q <= '0;
         end else if (stop_i) begin
            run_o <= 1'b0;
         end else if (take_o) begin
            off_q  <= at_end ? '0 : nxt[ADDR_W-1:0];
            wrap_o <= at_end;
            half_o <= at_half;
            if (autodis_i && (at_end || at_half)) run_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sab_rx_lane.sv
`timescale 1ns/1ps
module sab_rx_lane #(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned DATA_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic              take_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              we_o,
   output logic [ADDR_W-1:0] waddr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              word_irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_o       <= 1'b0;
         waddr_o    <= '0;
         wdata_o    <= '0;
         word_irq_o <= 1'b0;
      end else begin
         we_o       <= take_i;
         word_irq_o <= valid_i & ~take_i;
         if (take_i) begin
            waddr_o <= addr_i;
            wdata_o <= data_i;
         end
      end
   end
endmodule

// File: rtl/sab_tx_lane.sv
`timescale 1ns/1ps
module sab_tx_lane #(
   parameter int unsigned ADDR_W = 11
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              take_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              re_o,
   output logic [ADDR_W-1:0] raddr_o,
   output logic              load_o,
   output logic              word_irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         re_o       <= 1'b0;
         raddr_o    <= '0;
         load_o     <= 1'b0;
         word_irq_o <= 1'b0;
      end else begin
         re_o       <= take_i;
         load_o     <= re_o;
         word_irq_o <= req_i & ~take_i;
         if (take_i) raddr_o <= addr_i;
      end
   end
endmodule

// File: rtl/serial_autobuffer.sv
`timescale 1ns/1ps
module serial_autobuffer
   import sab_pkg::*;
#(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned SZ_W [NUM_SIZES] = '{8, 10, 12, 16},
   localparam int unsigned LEN_W = ADDR_W + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_start,
   input  logic              rx_stop,
   input  logic [ADDR_W-1:0] rx_base,
   input  logic [LEN_W-1:0]  rx_len,
   input  logic              rx_autodis,
   input  logic              tx_start,
   input  logic              tx_stop,
   input  logic [ADDR_W-1:0] tx_base,
   input  logic [LEN_W-1:0]  tx_len,
   input  logic              tx_autodis,
   input  logic [1:0]        word_size,
   input  logic              frame_cont,
   input  logic              rx_fsync,
   input  logic              rx_word_valid,
   input  logic [DATA_W-1:0] rx_word_data,
   input  logic              tx_fsync,
   input  logic              tx_word_req,
   output logic [DATA_W-1:0] tx_word_data,
   output logic              tx_word_load,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              rx_active,
   output logic              tx_active,
   output logic              rx_word_irq,
   output logic              rx_half_irq,
   output logic              rx_wrap_irq,
   output logic              rx_misalign_irq,
   output logic              tx_word_irq,
   output logic              tx_half_irq,
   output logic              tx_wrap_irq,
   output logic              tx_misalign_irq
);
   if (ADDR_W < 2 || ADDR_W > 16) begin : g_chk_addr
      $error("serial_autobuffer: ADDR_W out of range");
   end
   if (DATA_W < 8 || DATA_W > 32) begin : g_chk_data
      $error("serial_autobuffer: DATA_W out of range");
   end

   logic              rx_take, tx_take;
   logic [ADDR_W-1:0] rx_addr, tx_addr;
   logic [DATA_W-1:0] rx_trim;

   sab_ring #(.ADDR_W(ADDR_W)) u_rx_ring (
      .clk(clk), .rst_n(rst_n), .start_i(rx_start), .stop_i(rx_stop),
      .step_i(rx_word_valid), .fsync_i(rx_fsync), .cont_i(frame_cont),
      .autodis_i(rx_autodis), .base_i(rx_base), .len_i(rx_len),
      .run_o(rx_active), .take_o(rx_take), .addr_o(rx_addr),
      .half_o(rx_half_irq), .wrap_o(rx_wrap_irq), .mis_o(rx_misalign_irq)
   );

   sab_ring #(.ADDR_W(ADDR_W)) u_tx_ring (
      .clk(clk), .rst_n(rst_n), .start_i(tx_start), .stop_i(tx_stop),
      .step_i(tx_word_req), .fsync_i(tx_fsync), .cont_i(frame_cont),
      .autodis_i(tx_autodis), .base_i(tx_base), .len_i(tx_len),
      .run_o(tx_active), .take_o(tx_take), .addr_o(tx_addr),
      .half_o(tx_half_irq), .wrap_o(tx_wrap_irq), .mis_o(tx_misalign_irq)
   );

   sab_wmask #(.DATA_W(DATA_W), .SZ_W(SZ_W)) u_rx_mask (
      .sel_i(word_size), .din_i(rx_word_data), .dout_o(rx_trim)
   );

   sab_wmask #(.DATA_W(DATA_W), .SZ_W(SZ_W)) u_tx_mask (
      .sel_i(word_size), .din_i(mem_rd_data), .dout_o(tx_word_data)
   );

   sab_rx_lane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx_lane (
      .clk(clk), .rst_n(rst_n), .valid_i(rx_word_valid), .take_i(rx_take),
      .addr_i(rx_addr), .data_i(rx_trim), .we_o(mem_wr_en),
      .waddr_o(mem_wr_addr), .wdata_o(mem_wr_data), .word_irq_o(rx_word_irq)
   );

   sab_tx_lane #(.ADDR_W(ADDR_W)) u_tx_lane (
      .clk(clk), .rst_n(rst_n), .req_i(tx_word_req), .take_i(tx_take),
      .addr_i(tx_addr), .re_o(mem_rd_en), .raddr_o(mem_rd_addr),
      .load_o(tx_word_load), .word_irq_o(tx_word_irq)
   );
endmodule

// File: rtl/sab_checker.sv
`timescale 1ns/1ps
module sab_checker #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned NARROW_W = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              rx_word_valid,
   input logic              rx_active,
   input logic              rx_autodis,
   input logic [1:0]        word_size,
   input logic              frame_cont,
   input logic              mem_wr_en,
   input logic [DATA_W-1:0] mem_wr_data,
   input logic              mem_rd_en,
   input logic              tx_word_load,
   input logic              rx_word_irq,
   input logic              rx_half_irq,
   input logic              rx_wrap_irq,
   input logic              rx_misalign_irq
);
   AST_WR_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> $past(rx_active && rx_word_valid)); // R2
   AST_NARROW_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_en && $past(word_size) == 2'd0) |-> ((mem_wr_data >> NARROW_W) == '0)); // R3
   AST_HALF_WRAP_APART: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_half_irq && rx_wrap_irq)); // R4
   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_word_valid && !rx_active) |=> (rx_word_irq && !mem_wr_en)); // R5
   AST_AUTO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_half_irq || rx_wrap_irq) && $past(rx_autodis)) |-> !rx_active); // R6
   AST_MISALIGN_CONT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_misalign_irq |-> $past(frame_cont && rx_active)); // R7
   AST_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      tx_word_load |-> $past(mem_rd_en)); // R8
endmodule

bind serial_autobuffer sab_checker #(.DATA_W(DATA_W), .NARROW_W(SZ_W[0])) u_sab_chk (
   .clk(clk), .rst_n(rst_n), .rx_word_valid(rx_word_valid), .rx_active(rx_active),
   .rx_autodis(rx_autodis), .word_size(word_size), .frame_cont(frame_cont),
   .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data), .mem_rd_en(mem_rd_en),
   .tx_word_load(tx_word_load), .rx_word_irq(rx_word_irq), .rx_half_irq(rx_half_irq),
   .rx_wrap_irq(rx_wrap_irq), .rx_misalign_irq(rx_misalign_irq)
);

// File: tb/serial_autobuffer_tb_top.sv
`timescale 1ns/1ps
module serial_autobuffer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_start = 0, rx_stop = 0, rx_autodis = 0;
   logic        tx_start = 0, tx_stop = 0, tx_autodis = 0;
   logic [10:0] rx_base = '0, tx_base = '0;
   logic [11:0] rx_len = 12'd1, tx_len = 12'd1;
   logic [1:0]  word_size = 2'd3;
   logic        frame_cont = 0, rx_fsync = 0, tx_fsync = 0;
   logic        rx_word_valid = 0, tx_word_req = 0;
   logic [15:0] rx_word_data = '0;
   logic [15:0] tx_word_data, mem_wr_data, mem_rd_data;
   logic [10:0] mem_wr_addr, mem_rd_addr;
   logic        tx_word_load, mem_wr_en, mem_rd_en, rx_active, tx_active;
   logic        rx_word_irq, rx_half_irq, rx_wrap_irq, rx_misalign_irq;
   logic        tx_word_irq, tx_half_irq, tx_wrap_irq, tx_misalign_irq;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   serial_autobuffer dut_i (.*);

   function automatic logic [15:0] ram_word(logic [10:0] a);
      return {a[7:0], 8'h00} ^ {5'd0, a} ^ 16'hA5C3;
   endfunction

   initial mem_rd_data = '0;
   always @(posedge clk) if (mem_rd_en) mem_rd_data <= ram_word(mem_rd_addr);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // size[46:45] din[44:29] addr[28:18] data[17:2] half[1] wrap[0]
   localparam int NV = 8;
   localparam logic [46:0] VEC [NV] = '{
      {2'd0, 16'hA5C3, 11'h7FE, 16'h00C3, 1'b0, 1'b0},
      {2'd1, 16'hFFFF, 11'h7FF, 16'h03FF, 1'b0, 1'b0},
      {2'd2, 16'h1234, 11'h000, 16'h0234, 1'b1, 1'b0},
      {2'd3, 16'hBEEF, 11'h001, 16'hBEEF, 1'b0, 1'b0},
      {2'd0, 16'h0180, 11'h002, 16'h0080, 1'b0, 1'b0},
      {2'd1, 16'h0C01, 11'h003, 16'h0001, 1'b0, 1'b1},
      {2'd2, 16'hF00F, 11'h7FE, 16'h000F, 1'b0, 1'b0},
      {2'd3, 16'h0000, 11'h7FF, 16'h0000, 1'b0, 1'b0}
   };

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      chk("R1 mem_wr_en in reset", mem_wr_en, 0);
      rst_n = 1'b1;
      tick();
      chk("R1 rx_active", rx_active, 0);
      chk("R1 tx_active", tx_active, 0);
      chk("R1 strobes", {mem_wr_en, mem_rd_en, tx_word_load}, 0);
      chk("R1 irqs", {rx_word_irq, rx_half_irq, rx_wrap_irq, rx_misalign_irq,
                      tx_word_irq, tx_half_irq, tx_wrap_irq, tx_misalign_irq}, 0);

      // R5 pass-through while disarmed
      rx_word_valid = 1; rx_word_data = 16'h1111; tick();
      rx_word_valid = 0; tick();
      chk("R5 rx word irq", rx_word_irq, 0); // pulse already gone one cycle later
      rx_word_valid = 1; tick(); rx_word_valid = 0;
      chk("R5 rx word irq pulse", rx_word_irq, 1);
      chk("R5 no write", mem_wr_en, 0);

      // R9 arm receive, buffer across top of window
      rx_base = 11'h7FE; rx_len = 12'd6; frame_cont = 1;
      rx_start = 1; tick(); rx_start = 0;
      chk("R9 rx armed", rx_active, 1);
      chk("R9 tx stays disarmed", tx_active, 0);

      // R2 R3 R4 vector table
      for (int i = 0; i < NV; i++) begin
         word_size = VEC[i][46:45];
         rx_word_data = VEC[i][44:29];
         rx_word_valid = 1; tick(); rx_word_valid = 0;
         chk("R2 write strobe", mem_wr_en, 1);
         chk("R2 write addr", mem_wr_addr, VEC[i][28:18]);
         chk("R3 write data", mem_wr_data, VEC[i][17:2]);
         chk("R4 half irq", rx_half_irq, VEC[i][1]);
         chk("R4 wrap irq", rx_wrap_irq, VEC[i][0]);
      end

      // R7 offset now 2: sync in continuous mode flags, in burst mode not
      rx_fsync = 1; tick(); rx_fsync = 0;
      chk("R7 misalign cont", rx_misalign_irq, 1);
      frame_cont = 0;
      rx_fsync = 1; tick(); rx_fsync = 0;
      chk("R7 no misalign burst", rx_misalign_irq, 0);
      rx_stop = 1; tick(); rx_stop = 0;
      chk("R9 rx stop", rx_active, 0);
      frame_cont = 1;
      rx_start = 1; tick(); rx_start = 0;
      rx_fsync = 1; tick(); rx_fsync = 0;
      chk("R7 no misalign at base", rx_misalign_irq, 0);

      // R6 auto-stop at half of a 4-word buffer
      rx_base = 11'h100; rx_len = 12'd4; rx_autodis = 1; word_size = 2'd3;
      rx_start = 1; tick(); rx_start = 0;
      rx_word_data = 16'h0042; rx_word_valid = 1; tick(); rx_word_valid = 0;
      chk("R6 first write addr", mem_wr_addr, 11'h100);
      rx_word_valid = 1; tick(); rx_word_valid = 0;
      chk("R6 half at boundary", rx_half_irq, 1);
      chk("R6 disarmed", rx_active, 0);
      rx_word_valid = 1; tick(); rx_word_valid = 0;
      chk("R6 next word passes", rx_word_irq, 1);
      chk("R6 next word not written", mem_wr_en, 0);

      // R5 transmit pass-through
      tx_word_req = 1; tick(); tx_word_req = 0;
      chk("R5 tx word irq", tx_word_irq, 1);
      chk("R5 tx no read", mem_rd_en, 0);

      // R8 transmit, 2-word buffer at top of window, 10-bit words
      tx_base = 11'h7FF; tx_len = 12'd2; word_size = 2'd1;
      tx_start = 1; tick(); tx_start = 0;
      chk("R9 tx armed", tx_active, 1);
      tx_word_req = 1; tick(); tx_word_req = 0;
      chk("R8 read strobe", mem_rd_en, 1);
      chk("R8 read addr", mem_rd_addr, 11'h7FF);
      chk("R4 tx half", tx_half_irq, 1);
      tick();
      chk("R8 load", tx_word_load, 1);
      chk("R3 tx data trim", tx_word_data, {6'd0, ram_word(11'h7FF)[9:0]});
      tx_word_req = 1; tick(); tx_word_req = 0;
      chk("R8 read addr wrap", mem_rd_addr, 11'h000);
      chk("R4 tx wrap", tx_wrap_irq, 1);
      word_size = 2'd2;
      tick();
      chk("R3 tx data 12b", tx_word_data, {4'd0, ram_word(11'h000)[11:0]});
      tx_stop = 1; tick(); tx_stop = 0;
      chk("R9 tx stop", tx_active, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule